// File: doc/BRIEF.md
# Password-Gated One-Time-Programmable Byte Store

This block guards two 64-byte one-time-programmable arrays that sit in one 128-byte address space. Bytes 00h to 3Fh form bank 0 and bytes 40h to 7Fh form bank 1. A client opens a transaction with a one-cycle start pulse. The pulse carries a direction bit, a 64-bit key and a start address. The client then streams bytes with a per-byte strobe and closes the transaction with an end pulse.

The key is compared with one of two stored keys. A read uses the read key and a write uses the write key. On a mismatch the transaction is kept open but every byte in it is dropped. A write that is accepted lands at successive offsets of the bank it started in. At offset 63 it wraps back to offset 0 of that same bank. When the transaction closes, the bank locks for good, provided at least one byte was written. A read walks the whole 128-byte space and may cross from bank 0 into bank 1. After address 7Fh it wraps back to 00h.

The storage is a register file with a reset value, standing in for the real cells. The keys are elaboration parameters.

Top module: `otp_vault`

## Requirements
- R1: After reset, `txn_open`, `key_err`, `wr_refused`, `rd_valid` and `bank_locked` are all 0, and every byte of the store reads as FFh.
- R2: In a read transaction opened with the read key, each cycle with `byte_valid` high returns the byte at the current pointer. `rd_valid` is high and `rd_data` holds that byte in the cycle that follows the request edge.
- R3: The read pointer starts at `txn_addr` and advances by one per request. It runs from 3Fh into 40h and wraps from 7Fh to 00h.
- R4: In a write transaction opened with the write key on an unlocked bank, each byte with `byte_valid` high is stored at the pointer, and the pointer then advances.
- R5: During a write, the offset wraps from 63 back to 0 while the bank stays fixed. Later bytes overwrite earlier ones.
- R6: If the key does not match the key for the requested direction, `key_err` is 1 from the cycle after the start edge. In that transaction no byte is stored, `rd_valid` stays 0, and no bank locks.
- R7: An end pulse closes a write transaction that has stored at least one byte. It sets `bank_locked[b]` for its bank `b`, where bit 0 is 00h to 3Fh and bit 1 is 40h to 7Fh, and the lock never clears. A write transaction that stores no bytes leaves the lock clear.
- R8: A correctly keyed write that starts in a locked bank raises `wr_refused` and leaves `key_err` at 0. The bytes of that transaction are dropped and the bank contents do not change.
- R9: `key_err` and `wr_refused` hold their values until the next accepted start pulse. That pulse updates both flags, so a correctly keyed read clears both.
- R10: A start pulse while a transaction is open has no effect. The open transaction keeps its direction, its pointer and its flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Opens a transaction when none is open |
| txn_write | input | 1 | Direction at start: 1 write, 0 read |
| txn_key | input | KEY_W (64) | Key supplied with the start pulse |
| txn_addr | input | ADDR_W (7) | Start address of the transaction |
| txn_end | input | 1 | Closes the open transaction |
| byte_valid | input | 1 | Write byte strobe, or read request |
| byte_wdata | input | DATA_W (8) | Write byte |
| rd_valid | output | 1 | Read byte is present on `rd_data` |
| rd_data | output | DATA_W (8) | Read byte, held between reads |
| txn_open | output | 1 | A transaction is open |
| key_err | output | 1 | The last accepted start carried a wrong key |
| wr_refused | output | 1 | The last accepted write targeted a locked bank |
| bank_locked | output | NUM_BANKS (2) | Per-bank write-once lock |

## Verification
Every result appears exactly one clock edge after the input that causes it:
- `txn_open`, `key_err` and `wr_refused` follow the start edge.
- `rd_valid` and `rd_data` follow each request edge.
- `bank_locked` follows the end edge.

Inputs are driven on the falling edge, held through one rising edge, and the outputs are compared at the next falling edge. Every check therefore lands in the first cycle the result is due. A read stream is issued on consecutive cycles, so each returned byte is compared in its own cycle. Dropped bytes and refused writes are confirmed later by reading the same addresses back through a correctly keyed read.

// File: rtl/otp_vault_pkg.sv
`timescale 1ns/1ps
package otp_vault_pkg;

   // transaction state: idle, live (bytes act), drop (bytes ignored)
   typedef enum logic [1:0] {
      TXN_IDLE = 2'd0,
      TXN_LIVE = 2'd1,
      TXN_DROP = 2'd2
   } txn_state_e;

endpackage

// File: rtl/otp_key_check.sv
`timescale 1ns/1ps
module otp_key_check #(
   parameter int KEY_W = 64,
   parameter int SLICE_W = 16,
   parameter logic [KEY_W-1:0] RD_KEY = '0,
   parameter logic [KEY_W-1:0] WR_KEY = '1
) (
   input  logic [KEY_W-1:0] key,
   input  logic             is_write,
   output logic             match
);
   localparam int NSLICE = (SLICE_W >= KEY_W) ? 1 : KEY_W / SLICE_W;

   logic [KEY_W-1:0] ref_key;
   assign ref_key = is_write ? WR_KEY : RD_KEY;

   if (SLICE_W >= KEY_W) begin : g_flat
      assign match = (key == ref_key);
   end else begin : g_sliced
      logic [NSLICE-1:0] hit;
      for (genvar s = 0; s < NSLICE; s++) begin : g_slice
         assign hit[s] = (key[s*SLICE_W +: SLICE_W] == ref_key[s*SLICE_W +: SLICE_W]);
      end
      assign match = &hit;
   end
endmodule

// File: rtl/otp_addr_ptr.sv
`timescale 1ns/1ps
module otp_addr_ptr #(
   parameter int OFF_W = 6,
   parameter int BANK_W = 1,
   localparam int ADDR_W = OFF_W + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   input  logic              bank_wrap,
   output logic [ADDR_W-1:0] ptr
);
   logic [OFF_W-1:0] off_next;
   logic [ADDR_W-1:0] flat_next;

   assign off_next  = ptr[OFF_W-1:0] + 1'b1;
   assign flat_next = ptr + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= load_addr;
      end else if (step) begin
         if (bank_wrap) begin
            ptr <= {ptr[ADDR_W-1:OFF_W], off_next};
         end else begin
            ptr <= flat_next;
         end
      end
   end
endmodule

// File: rtl/otp_bank_store.sv
`timescale 1ns/1ps
module otp_bank_store #(
   parameter int DATA_W = 8,
   parameter int OFF_W = 6,
   parameter int NUM_BANKS = 2,
   parameter logic [DATA_W-1:0] ERASED_VAL = '1,
   localparam int BANK_W = $clog2(NUM_BANKS),
   localparam int ADDR_W = OFF_W + BANK_W,
   localparam int BANK_BYTES = 1 << OFF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [NUM_BANKS-1:0] lock_req,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_byte,
   output logic [NUM_BANKS-1:0] locked
);
   logic [DATA_W-1:0] bank_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] cells [BANK_BYTES];
      logic              sel_wr;

      assign sel_wr = wr_en && (wr_addr[ADDR_W-1:OFF_W] == BANK_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < BANK_BYTES; i++) begin
               cells[i] <= ERASED_VAL;
            end
         end else if (sel_wr) begin
            cells[wr_addr[OFF_W-1:0]] <= wr_data;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            locked[b] <= 1'b0;
         end else if (lock_req[b]) begin
            locked[b] <= 1'b1;
         end
      end

      assign bank_rd[b] = cells[rd_addr[OFF_W-1:0]];
   end

   assign rd_byte = bank_rd[rd_addr[ADDR_W-1:OFF_W]];
endmodule

// File: rtl/otp_vault.sv
`timescale 1ns/1ps
module otp_vault
   import otp_vault_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BANK_BYTES = 64,
   parameter int NUM_BANKS = 2,
   parameter int KEY_W = 64,
   parameter int KEY_SLICE_W = 16,
   parameter logic [KEY_W-1:0] RD_KEY = 64'h0123_4567_89AB_CDEF,
   parameter logic [KEY_W-1:0] WR_KEY = 64'hFEDC_BA98_7654_3210,
   parameter logic [DATA_W-1:0] ERASED_VAL = '1,
   localparam int OFF_W = $clog2(BANK_BYTES),
   localparam int BANK_W = $clog2(NUM_BANKS),
   localparam int ADDR_W = OFF_W + BANK_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 txn_start,
   input  logic                 txn_write,
   input  logic [KEY_W-1:0]     txn_key,
   input  logic [ADDR_W-1:0]    txn_addr,
   input  logic                 txn_end,
   input  logic                 byte_valid,
   input  logic [DATA_W-1:0]    byte_wdata,
   output logic                 rd_valid,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 txn_open,
   output logic                 key_err,
   output logic                 wr_refused,
   output logic [NUM_BANKS-1:0] bank_locked
);
   // elaboration-time parameter checks
   if (BANK_BYTES < 2 || (BANK_BYTES & (BANK_BYTES - 1)) != 0) begin : g_bad_bank_bytes
      $error("otp_vault: BANK_BYTES must be a power of two");
   end
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_num_banks
      $error("otp_vault: NUM_BANKS must be a power of two of at least 2");
   end
   if (KEY_SLICE_W < KEY_W && (KEY_W % KEY_SLICE_W) != 0) begin : g_bad_slice
      $error("otp_vault: KEY_SLICE_W must divide KEY_W");
   end
   if (RD_KEY == WR_KEY) begin : g_bad_keys
      $error("otp_vault: read and write keys must differ");
   end

   txn_state_e            state_q;
   logic                  mode_wr_q;
   logic                  touched_q;
   logic                  key_ok;
   logic                  accept;
   logic                  live;
   logic                  wr_en;
   logic                  rd_en;
   logic                  start_locked;
   logic                  drop_start;
   logic [ADDR_W-1:0]     ptr;
   logic [BANK_W-1:0]     ptr_bank;
   logic [BANK_W-1:0]     start_bank;
   logic [DATA_W-1:0]     rd_byte;
   logic [NUM_BANKS-1:0]  locked;
   logic [NUM_BANKS-1:0]  lock_req;

   otp_key_check #(
      .KEY_W   (KEY_W),
      .SLICE_W (KEY_SLICE_W),
      .RD_KEY  (RD_KEY),
      .WR_KEY  (WR_KEY)
   ) u_key (
      .key      (txn_key),
      .is_write (txn_write),
      .match    (key_ok)
   );

   assign accept       = txn_start && (state_q == TXN_IDLE);
   assign live         = (state_q == TXN_LIVE);
   assign wr_en        = live && mode_wr_q && byte_valid;
   assign rd_en        = live && !mode_wr_q && byte_valid;
   assign start_bank   = txn_addr[ADDR_W-1:OFF_W];
   assign ptr_bank     = ptr[ADDR_W-1:OFF_W];
   assign start_locked = locked[start_bank];
   assign drop_start   = !key_ok || (txn_write && start_locked);

   otp_addr_ptr #(
      .OFF_W  (OFF_W),
      .BANK_W (BANK_W)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_addr (txn_addr),
      .step      (wr_en || rd_en),
      .bank_wrap (mode_wr_q),
      .ptr       (ptr)
   );

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         lock_req[b] = txn_end && live && mode_wr_q && (touched_q || wr_en)
                       && (ptr_bank == BANK_W'(b));
      end
   end

   otp_bank_store #(
      .DATA_W     (DATA_W),
      .OFF_W      (OFF_W),
      .NUM_BANKS  (NUM_BANKS),
      .ERASED_VAL (ERASED_VAL)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (ptr),
      .wr_data  (byte_wdata),
      .lock_req (lock_req),
      .rd_addr  (ptr),
      .rd_byte  (rd_byte),
      .locked   (locked)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= TXN_IDLE;
         mode_wr_q  <= 1'b0;
         touched_q  <= 1'b0;
         key_err    <= 1'b0;
         wr_refused <= 1'b0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data <= rd_byte;
         end
         if (accept) begin
            mode_wr_q  <= txn_write;
            touched_q  <= 1'b0;
            key_err    <= !key_ok;
            wr_refused <= key_ok && txn_write && start_locked;
            state_q    <= drop_start ? TXN_DROP : TXN_LIVE;
         end else if (state_q != TXN_IDLE) begin
            if (wr_en) begin
               touched_q <= 1'b1;
            end
            if (txn_end) begin
               state_q <= TXN_IDLE;
            end
         end
      end
   end

   assign txn_open    = (state_q != TXN_IDLE);
   assign bank_locked = locked;
endmodule

// File: rtl/otp_vault_checker.sv
`timescale 1ns/1ps
module otp_vault_checker #(
   parameter int NUM_BANKS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 txn_start,
   input logic                 txn_end,
   input logic                 byte_valid,
   input logic                 txn_open,
   input logic                 rd_valid,
   input logic                 key_err,
   input logic                 wr_refused,
   input logic [NUM_BANKS-1:0] bank_locked
);
   // a returned byte always answers a request inside an open transaction
   assert_rd_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(byte_valid && txn_open));

   // a wrong key blocks every read in its transaction
   assert_bad_key_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (key_err && txn_open && byte_valid) |=> !rd_valid);

   // locks never clear
   assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((bank_locked & $past(bank_locked)) == $past(bank_locked)));

   // a lock only appears when an open transaction ends
   assert_lock_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_locked != $past(bank_locked)) |-> $past(txn_end && txn_open));

   // a refusal is only reported for a correct key
   assert_refused_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(key_err && wr_refused));

   // flags change only at an accepted start
   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(key_err) || $changed(wr_refused)) |-> $past(txn_start && !txn_open));
endmodule

bind otp_vault otp_vault_checker #(.NUM_BANKS(NUM_BANKS)) u_otp_vault_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .txn_start   (txn_start),
   .txn_end     (txn_end),
   .byte_valid  (byte_valid),
   .txn_open    (txn_open),
   .rd_valid    (rd_valid),
   .key_err     (key_err),
   .wr_refused  (wr_refused),
   .bank_locked (bank_locked)
);

// File: tb/otp_vault_bench.sv
`timescale 1ns/1ps
module otp_vault_bench;
   localparam logic [63:0] RKEY = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] WKEY = 64'hFEDC_BA98_7654_3210;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        txn_start = 1'b0;
   logic        txn_write = 1'b0;
   logic [63:0] txn_key = '0;
   logic [6:0]  txn_addr = '0;
   logic        txn_end = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_wdata = '0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        txn_open;
   logic        key_err;
   logic        wr_refused;
   logic [1:0]  bank_locked;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [7:0] exp_mem [128];

   always #2.5 clk = ~clk;

   otp_vault u_otp_vault (
      .clk (clk), .rst_n (rst_n), .txn_start (txn_start), .txn_write (txn_write),
      .txn_key (txn_key), .txn_addr (txn_addr), .txn_end (txn_end),
      .byte_valid (byte_valid), .byte_wdata (byte_wdata), .rd_valid (rd_valid),
      .rd_data (rd_data), .txn_open (txn_open), .key_err (key_err),
      .wr_refused (wr_refused), .bank_locked (bank_locked)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // all tasks are entered and left at a falling edge
   task automatic start_txn(input logic wr, input logic [63:0] key, input int addr);
      txn_start = 1'b1; txn_write = wr; txn_key = key; txn_addr = 7'(addr);
      @(negedge clk);
      txn_start = 1'b0; txn_write = 1'b0; txn_key = '0;
   endtask

   task automatic end_txn();
      txn_end = 1'b1;
      @(negedge clk);
      txn_end = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d);
      byte_valid = 1'b1; byte_wdata = d;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic read_back(input string tag, input int addr, input int n);
      start_txn(1'b0, RKEY, addr);
      check({tag, " open/no error"}, {txn_open, key_err}, 2'b10);
      for (int i = 0; i < n; i++) begin
         send_byte(8'h00);
         check({tag, " rd_valid"}, rd_valid, 1'b1);
         check({tag, " rd_data"}, rd_data, exp_mem[(addr + i) % 128]);
      end
      end_txn();
   endtask

   task automatic write_bytes(input int addr, input int n, input logic [7:0] base,
                              input bit lands);
      for (int i = 0; i < n; i++) begin
         send_byte(base + 8'(i));
         if (lands) exp_mem[(addr & 'h40) | ((addr + i) & 'h3F)] = base + 8'(i);
      end
   endtask

   task automatic t_reset();
      check("R1 txn_open", txn_open, 1'b0);
      check("R1 key_err", key_err, 1'b0);
      check("R1 wr_refused", wr_refused, 1'b0);
      check("R1 rd_valid", rd_valid, 1'b0);
      check("R1 bank_locked", bank_locked, 2'b00);
      // R2, R3: one stream across the bank boundary, all erased
      read_back("R1 R2 R3 erased sweep", 0, 128);
   endtask

   task automatic t_bad_key();
      start_txn(1'b1, RKEY, 'h05);
      check("R6 write with read key: key_err", key_err, 1'b1);
      check("R6 write with read key: open", txn_open, 1'b1);
      write_bytes('h05, 3, 8'h11, 1'b0);
      end_txn();
      check("R6 no lock after bad key", bank_locked, 2'b00);
      start_txn(1'b0, WKEY, 'h00);
      check("R6 read with write key: key_err", key_err, 1'b1);
      send_byte(8'h00);
      check("R6 read with bad key: rd_valid", rd_valid, 1'b0);
      end_txn();
      read_back("R6 bank 0 unchanged", 'h00, 16);
   endtask

   task automatic t_write_wrap();
      start_txn(1'b1, WKEY, 'h7C);
      check("R4 write open, no flags", {txn_open, key_err, wr_refused}, 3'b100);
      write_bytes('h7C, 6, 8'hA0, 1'b1);
      check("R7 still unlocked before end", bank_locked, 2'b00);
      end_txn();
      check("R7 bank 1 locked", bank_locked, 2'b10);
      check("R5 offset wrap stored at 40h", exp_mem['h40], 8'hA4);
      read_back("R4 R5 bank 1 tail/head", 'h7C, 4);
      read_back("R5 bank 1 head", 'h40, 3);
      read_back("R3 wrap 7Fh to 00h", 'h7E, 4);
   endtask

   task automatic t_refused();
      start_txn(1'b1, WKEY, 'h50);
      check("R8 wr_refused", wr_refused, 1'b1);
      check("R8 key_err clear", key_err, 1'b0);
      write_bytes('h50, 4, 8'h33, 1'b0);
      end_txn();
      check("R9 wr_refused held after end", wr_refused, 1'b1);
      read_back("R8 bank 1 unchanged", 'h40, 64);
      check("R9 flags cleared by next start", {key_err, wr_refused}, 2'b00);
   endtask

   task automatic t_bank0();
      start_txn(1'b1, WKEY, 'h20);
      end_txn();
      check("R7 empty write leaves lock clear", bank_locked, 2'b10);
      start_txn(1'b1, WKEY, 'h3E);
      check("R4 bank 0 write accepted", {key_err, wr_refused}, 2'b00);
      write_bytes('h3E, 66, 8'h40, 1'b1);
      end_txn();
      check("R7 both banks locked", bank_locked, 2'b11);
      read_back("R5 bank 0 after long wrap", 'h00, 64);
   endtask

   task automatic t_restart_ignored();
      start_txn(1'b0, RKEY, 'h10);
      send_byte(8'h00);
      check("R10 first byte", rd_data, exp_mem['h10]);
      start_txn(1'b1, 64'h0, 'h00);
      check("R10 flags untouched", {txn_open, key_err, wr_refused}, 3'b100);
      send_byte(8'h00);
      check("R10 read continues: rd_valid", rd_valid, 1'b1);
      check("R10 read continues: rd_data", rd_data, exp_mem['h11]);
      end_txn();
      check("R10 closed", txn_open, 1'b0);
      byte_valid = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0;
      check("R2 no read outside transaction", rd_valid, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) exp_mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bad_key();
      t_write_wrap();
      t_refused();
      t_bank0();
      t_restart_ignored();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule